// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block collects every interrupt cause of a serial port into one status word and one interrupt line. It watches line-error and modem-change events, the receive FIFO fill level against its trigger, an idle timer on the receive side, the transmit FIFO level and empty flag, and flow-control and wake-up events. Each cause has its own pending flag and its own rule for clearing: reading a particular register, writing the transmit holding register, reading the status word, or the condition going away.

Software sees the highest-priority enabled cause as a fixed code in the status word. Lower causes stay pending and come up in turn once the higher one has been serviced. The enable register holds one bit per cause group. Two of its bits, sleep/wake-up and Xoff, act only while an external extended-feature input is high. The receive idle timer counts bit-time ticks while data waits in the FIFO. It fires after four character times plus twelve bit times.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status word is 0x01, the interrupt line is 0 and the enable register reads 0x00.
- R2: An enable write stores data bits 5:0. Bits 7:6 always read back as 0 and enable nothing. Bit 0 enables receive data and timeout, bit 1 transmit ready, bit 2 line status, bit 3 modem status, bit 4 sleep/wake-up, and bit 5 Xoff.
- R3: Enable bits 4 and 5 take effect only while `ext_en` is 1. Otherwise the wake-up and Xoff causes are never reported and `sleep_en` is 0.
- R4: The status word reports the highest enabled pending cause. The order from highest to lowest is line status 0x06, receive timeout 0x0C, receive data 0x04, transmit ready 0x02, modem status 0x00, Xoff 0x10, wake-up 0x20. The word is 0x01 when nothing enabled is pending.
- R5: Any bit of `lsr_evt` sets the line-status cause. Only `lsr_rd` clears it. A status-word read does not.
- R6: The receive-data cause is a level: it is active exactly while `rx_count >= rx_trig`.
- R7: With `rx_count` nonzero, the timeout cause sets on the (4*CHAR_BITS+12)-th `bit_tick` counted since the last `rx_push`, `rhr_rd` or empty FIFO. `rhr_rd` clears it.
- R8: Transmit ready sets when `tx_count <= tx_trig` becomes true or `tx_empty` rises. It clears on `thr_wr`, or on `isr_rd` while it is the reported cause.
- R9: Any bit of `msr_evt` sets the modem-status cause. Only `msr_rd` clears it.
- R10: `xoff_det` sets the Xoff cause. It clears on `xon_det`, or on `isr_rd` while it is the reported cause.
- R11: `sleep_exit` sets the wake-up cause. It clears on `isr_rd` while it is the reported cause.
- R12: A status-word read clears at most the reported cause. Lower pending causes stay and are reported next.
- R13: `irq` is 1 exactly when some enabled cause is pending. A disabled cause stays pending and is reported once it is enabled.
- R14: When a cause's set and clear events arrive in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extended-feature enable that gates enable bits 4 and 5 |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| lsr_evt | input | 4 | Line-error events (line-status bits 1 to 4) |
| msr_evt | input | 4 | Modem-change events (modem-status bits 0 to 3) |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_push | input | 1 | A character entered the receive FIFO |
| bit_tick | input | 1 | One pulse per bit time |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_trig | input | CNT_W | Transmit trigger level |
| tx_empty | input | 1 | Transmit FIFO empty |
| xoff_det | input | 1 | Xoff character detected |
| xon_det | input | 1 | Xon character detected |
| sleep_exit | input | 1 | Port left sleep mode |
| isr_rd | input | 1 | Status word read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr | output | 8 | Status word with the code of the reported cause |
| irq | output | 1 | Interrupt line |
| sleep_en | output | 1 | Effective sleep enable |

## Verification
The bench builds the block with CNT_W = 7, which covers a 64-entry FIFO and lets trigger comparisons hit both ends of the count range. It uses CHAR_BITS = 3, so the idle timeout is 24 bit ticks. With that short window, random runs reach timeout firings and restarts often, while the directed case still checks the exact tick on which the timeout fires. Random strobes, including coincident set and clear events, run against a bench model. That reaches priority collisions, status reads with several causes pending, and extended-enable toggles.

// File: rtl/uic_pkg.sv
package uic_pkg;

  localparam int SRC_N = 7;

  // Source index, 0 is the highest priority
  localparam int SRC_LSR  = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_TXR  = 3;
  localparam int SRC_MSR  = 4;
  localparam int SRC_XOFF = 5;
  localparam int SRC_WAKE = 6;

  // Sources held in a pending flop; the rest pass through as levels
  localparam logic [SRC_N-1:0] SRC_LATCHED = 7'b111_1011;

  localparam logic [7:0] CODE_NONE = 8'h01;

  function automatic logic [7:0] src_code(input int idx);
    logic [7:0] c;
    case (idx)
      SRC_LSR:  c = 8'h06;
      SRC_TMO:  c = 8'h0C;
      SRC_RXD:  c = 8'h04;
      SRC_TXR:  c = 8'h02;
      SRC_MSR:  c = 8'h00;
      SRC_XOFF: c = 8'h10;
      SRC_WAKE: c = 8'h20;
      default:  c = CODE_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/uic_rst_sync.sv
module uic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/uic_ier_reg.sv
module uic_ier_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       ext_en,
  output logic [7:0] rdata,
  output logic [5:0] eff
);
  logic [5:0] ier_q;
  logic [5:0] ier_d;

  always_comb begin
    ier_d = ier_q;
    if (wr) ier_d = wdata[5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  assign rdata = {2'b00, ier_q};
  // Extended bits act only with the feature input high
  assign eff   = {ier_q[5:4] & {2{ext_en}}, ier_q[3:0]};
endmodule

// File: rtl/uic_rx_timer.sv
module uic_rx_timer #(
  parameter int CHAR_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic has_data,
  input  logic restart,
  input  logic fired,
  output logic hit
);
  localparam int LIMIT = 4 * CHAR_BITS + 12;
  localparam int TW    = $clog2(LIMIT);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          hit_c;

  always_comb begin
    cnt_d = cnt_q;
    hit_c = 1'b0;
    if (restart || !has_data) begin
      cnt_d = '0;
    end else if (bit_tick && !fired) begin
      if (cnt_q == LAST) begin
        hit_c = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = hit_c;
endmodule

// File: rtl/uic_src_latch.sv
module uic_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_q;
  logic pend_d;

  // A set in the same cycle as a clear wins
  always_comb pend_d = set | (pend_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/uic_prio_enc.sv
module uic_prio_enc
  import uic_pkg::*;
(
  input  logic [SRC_N-1:0] act,
  output logic [7:0]       code,
  output logic [SRC_N-1:0] sel
);
  always_comb begin
    code = CODE_NONE;
    sel  = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (act[i]) begin
        code = src_code(i);
        sel  = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uic_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int CHAR_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [7:0]       ier_rdata,
  input  logic [3:0]       lsr_evt,
  input  logic [3:0]       msr_evt,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] tx_trig,
  input  logic             tx_empty,
  input  logic             xoff_det,
  input  logic             xon_det,
  input  logic             sleep_exit,
  input  logic             isr_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  output logic [7:0]       isr,
  output logic             irq,
  output logic             sleep_en
);
  logic             rst_ns;
  logic [5:0]       ien;
  logic [SRC_N-1:0] set_v, clr_v, pend, en_v, act, sel;
  logic             rx_lvl, tx_lvl, tmo_hit;
  logic             tx_lvl_q, tx_emp_q, tx_lvl_d, tx_emp_d;

  uic_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  uic_ier_reg u_ier (
    .clk(clk), .rst_n(rst_ns), .wr(ier_wr), .wdata(ier_wdata),
    .ext_en(ext_en), .rdata(ier_rdata), .eff(ien)
  );

  uic_rx_timer #(.CHAR_BITS(CHAR_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .bit_tick(bit_tick),
    .has_data(rx_count != '0), .restart(rx_push | rhr_rd),
    .fired(pend[SRC_TMO]), .hit(tmo_hit)
  );

  assign rx_lvl = rx_count >= rx_trig;
  assign tx_lvl = tx_count <= tx_trig;

  // Edge memory for transmit-ready events; reset high so that a level
  // already present at reset does not count as an event
  always_comb begin
    tx_lvl_d = tx_lvl;
    tx_emp_d = tx_empty;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tx_lvl_q <= 1'b1;
      tx_emp_q <= 1'b1;
    end else begin
      tx_lvl_q <= tx_lvl_d;
      tx_emp_q <= tx_emp_d;
    end
  end

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_LSR]  = |lsr_evt;
    clr_v[SRC_LSR]  = lsr_rd;
    set_v[SRC_TMO]  = tmo_hit;
    clr_v[SRC_TMO]  = rhr_rd;
    set_v[SRC_RXD]  = rx_lvl;
    clr_v[SRC_RXD]  = 1'b0;
    set_v[SRC_TXR]  = (tx_lvl & ~tx_lvl_q) | (tx_empty & ~tx_emp_q);
    clr_v[SRC_TXR]  = thr_wr | (isr_rd & sel[SRC_TXR]);
    set_v[SRC_MSR]  = |msr_evt;
    clr_v[SRC_MSR]  = msr_rd;
    set_v[SRC_XOFF] = xoff_det;
    clr_v[SRC_XOFF] = xon_det | (isr_rd & sel[SRC_XOFF]);
    set_v[SRC_WAKE] = sleep_exit;
    clr_v[SRC_WAKE] = isr_rd & sel[SRC_WAKE];
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    if (SRC_LATCHED[g]) begin : g_flop
      uic_src_latch u_lat (
        .clk(clk), .rst_n(rst_ns), .set(set_v[g]), .clr(clr_v[g]), .pend(pend[g])
      );
    end else begin : g_level
      assign pend[g] = set_v[g] & ~clr_v[g];
    end
  end

  always_comb begin
    en_v = '0;
    en_v[SRC_LSR]  = ien[2];
    en_v[SRC_TMO]  = ien[0];
    en_v[SRC_RXD]  = ien[0];
    en_v[SRC_TXR]  = ien[1];
    en_v[SRC_MSR]  = ien[3];
    en_v[SRC_XOFF] = ien[5];
    en_v[SRC_WAKE] = ien[4];
  end

  assign act = pend & en_v;

  uic_prio_enc u_enc (.act(act), .code(isr), .sel(sel));

  assign irq      = |act;
  assign sleep_en = ien[4];
endmodule

// File: rtl/uic_checker.sv
module uic_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             ext_en,
  input logic             ier_wr,
  input logic [7:0]       ier_rdata,
  input logic [3:0]       lsr_evt,
  input logic [3:0]       msr_evt,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_trig,
  input logic             lsr_rd,
  input logic             msr_rd,
  input logic             rhr_rd,
  input logic [7:0]       isr,
  input logic             irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    ier_rdata[7:6] == 2'b00); // R2

  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_ns)
    !ext_en |-> (isr != 8'h10 && isr != 8'h20)); // R3

  AST_LSR_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (isr == 8'h06 && !lsr_rd && !ier_wr) |=> isr == 8'h06); // R5

  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_ns)
    (lsr_rd && lsr_evt == 4'h0) |=> isr != 8'h06); // R5

  AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_ns)
    isr == 8'h04 |-> rx_count >= rx_trig); // R6

  AST_RHR_CLEAR: assert property (@(posedge clk) disable iff (!rst_ns)
    rhr_rd |=> isr != 8'h0C); // R7

  AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_ns)
    (msr_rd && msr_evt == 4'h0) |=> isr != 8'h00); // R9

  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_ns)
    irq == (isr != 8'h01)); // R13
endmodule

bind uart_irq_ctrl uic_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .ext_en(ext_en), .ier_wr(ier_wr),
  .ier_rdata(ier_rdata), .lsr_evt(lsr_evt), .msr_evt(msr_evt),
  .rx_count(rx_count), .rx_trig(rx_trig), .lsr_rd(lsr_rd),
  .msr_rd(msr_rd), .rhr_rd(rhr_rd), .isr(isr), .irq(irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CW  = 7;
  localparam int CB  = 3;
  localparam int LIM = 4 * CB + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0, ier_wr = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [3:0] lsr_evt = '0, msr_evt = '0;
  logic [CW-1:0] rx_count = '0, rx_trig = 7'd8, tx_count = 7'd10, tx_trig = 7'd2;
  logic rx_push = 0, bit_tick = 0, tx_empty = 0, xoff_det = 0, xon_det = 0;
  logic sleep_exit = 0, isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic [7:0] ier_rdata, isr;
  logic irq, sleep_en;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.CNT_W(CW), .CHAR_BITS(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ier_wr(ier_wr),
    .ier_wdata(ier_wdata), .ier_rdata(ier_rdata), .lsr_evt(lsr_evt),
    .msr_evt(msr_evt), .rx_count(rx_count), .rx_trig(rx_trig),
    .rx_push(rx_push), .bit_tick(bit_tick), .tx_count(tx_count),
    .tx_trig(tx_trig), .tx_empty(tx_empty), .xoff_det(xoff_det),
    .xon_det(xon_det), .sleep_exit(sleep_exit), .isr_rd(isr_rd),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rhr_rd(rhr_rd), .thr_wr(thr_wr),
    .isr(isr), .irq(irq), .sleep_en(sleep_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model state: pending flags indexed by priority (0 highest)
  logic [5:0] m_ier = '0;
  logic [6:0] m_p = '0;
  int m_tcnt = 0;
  logic m_txl = 1'b1, m_txe = 1'b1;

  function automatic logic [6:0] m_act();
    logic [6:0] p, e;
    p = m_p;
    p[2] = (rx_count >= rx_trig);
    e = {m_ier[4] & ext_en, m_ier[5] & ext_en, m_ier[3], m_ier[1], m_ier[0], m_ier[0], m_ier[2]};
    return p & e;
  endfunction

  function automatic logic [7:0] code_of(input logic [6:0] a);
    logic [7:0] t [7] = '{8'h06, 8'h0C, 8'h04, 8'h02, 8'h00, 8'h10, 8'h20};
    for (int i = 0; i < 7; i++) if (a[i]) return t[i];
    return 8'h01;
  endfunction

  function automatic logic [6:0] top_of(input logic [6:0] a);
    for (int i = 0; i < 7; i++) if (a[i]) return 7'(1 << i);
    return '0;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [6:0] a, s, set, clr;
    logic txl;
    bit fire;
    a = m_act();
    s = top_of(a);
    txl = (tx_count <= tx_trig);
    fire = 0;
    if (rx_push || rhr_rd || rx_count == '0) m_tcnt = 0;
    else if (bit_tick && !m_p[1]) begin
      if (m_tcnt == LIM - 1) begin fire = 1; m_tcnt = 0; end
      else m_tcnt++;
    end
    set = {sleep_exit, xoff_det, |msr_evt, (txl & ~m_txl) | (tx_empty & ~m_txe), 1'b0, fire, |lsr_evt};
    clr = {isr_rd & s[6], xon_det | (isr_rd & s[5]), msr_rd, thr_wr | (isr_rd & s[3]), 1'b0, rhr_rd, lsr_rd};
    m_p = set | (m_p & ~clr);
    m_txl = txl;
    m_txe = tx_empty;
    if (ier_wr) m_ier = ier_wdata[5:0];
  endtask

  // One clock: compare against model, advance model, clear strobes
  task automatic step();
    #1;
    chk(isr, code_of(m_act()), "R4 status word");
    chk({7'b0, irq}, {7'b0, |m_act()}, "R13 irq");
    chk(ier_rdata, {2'b00, m_ier}, "R2 enable readback");
    chk({7'b0, sleep_en}, {7'b0, m_ier[4] & ext_en}, "R3 sleep_en");
    model_update();
    @(negedge clk);
    {ier_wr, rx_push, xoff_det, xon_det, sleep_exit} = '0;
    {isr_rd, lsr_rd, msr_rd, rhr_rd, thr_wr} = '0;
    lsr_evt = '0; msr_evt = '0;
    #1;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(isr, 8'h01, "R1 reset status");
    chk({7'b0, irq}, 8'h00, "R1 reset irq");
    chk(ier_rdata, 8'h00, "R1 reset enable");

    // R2 / R3 / R10
    wr_ier(8'hFF);
    chk(ier_rdata, 8'h3F, "R2 reserved bits read 0");
    xoff_det = 1; step();
    chk(isr, 8'h01, "R3 Xoff masked without ext_en");
    ext_en = 1; #1;
    chk(isr, 8'h10, "R3 Xoff shown with ext_en");
    xon_det = 1; step();
    chk(isr, 8'h01, "R10 Xon clears Xoff");

    // R5 / R9 / R12
    lsr_evt = 4'b0100; msr_evt = 4'b0001; step();
    chk(isr, 8'h06, "R5 line status reported");
    isr_rd = 1; step();
    chk(isr, 8'h06, "R5 status read keeps line status");
    lsr_rd = 1; step();
    chk(isr, 8'h00, "R9 modem status after line status");
    msr_rd = 1; step();
    chk(isr, 8'h01, "R9 modem read clears");

    // R6
    rx_trig = 7'd4; rx_count = 7'd4; #1;
    chk(isr, 8'h04, "R6 rx at trigger");
    rx_count = 7'd3; #1;
    chk(isr, 8'h01, "R6 rx below trigger");
    rx_count = '0; step();

    // R7
    rx_trig = 7'd8; rx_count = 7'd1; bit_tick = 1;
    repeat (LIM - 1) step();
    chk(isr, 8'h01, "R7 no timeout one tick early");
    step();
    chk(isr, 8'h0C, "R7 timeout fires");
    bit_tick = 0; rhr_rd = 1; step();
    chk(isr, 8'h01, "R7 rhr read clears timeout");
    rx_count = '0; step();

    // R8
    tx_count = 7'd2; step();
    chk(isr, 8'h02, "R8 tx level entry sets");
    thr_wr = 1; step();
    chk(isr, 8'h01, "R8 thr write clears");
    tx_empty = 1; step();
    chk(isr, 8'h02, "R8 tx empty rise sets");
    isr_rd = 1; step();
    chk(isr, 8'h01, "R8 status read clears");

    // R11 / R12
    tx_empty = 0; step();
    tx_empty = 1; sleep_exit = 1; step();
    chk(isr, 8'h02, "R12 tx above wake-up");
    isr_rd = 1; step();
    chk(isr, 8'h20, "R12 wake-up kept after read");
    isr_rd = 1; step();
    chk(isr, 8'h01, "R11 status read clears wake-up");

    // R13 / R2
    wr_ier(8'hC0);
    msr_evt = 4'b1000; step();
    chk({7'b0, irq}, 8'h00, "R2 bits 7:6 enable nothing");
    chk(isr, 8'h01, "R13 disabled source hidden");
    wr_ier(8'h08);
    chk(isr, 8'h00, "R13 pending shown once enabled");
    chk({7'b0, irq}, 8'h01, "R13 irq raised");
    msr_rd = 1; step();

    // R14
    wr_ier(8'h3F);
    lsr_evt = 4'b0001; lsr_rd = 1; step();
    chk(isr, 8'h06, "R14 set beats clear");
    lsr_rd = 1; step();
    chk(isr, 8'h01, "R5 line status read clears");

    // Random phase
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 20 == 0) lsr_evt = 4'($urandom);
      if ($urandom % 20 == 0) msr_evt = 4'($urandom);
      if ($urandom % 15 == 0) rx_count = 7'($urandom % 20);
      if ($urandom % 40 == 0) rx_trig = 7'(1 + $urandom % 16);
      if ($urandom % 15 == 0) tx_count = 7'($urandom % 12);
      if ($urandom % 40 == 0) tx_trig = 7'($urandom % 8);
      if ($urandom % 12 == 0) tx_empty = ~tx_empty;
      if ($urandom % 60 == 0) ext_en = ~ext_en;
      if ($urandom % 40 == 0) begin ier_wr = 1; ier_wdata = 8'($urandom); end
      bit_tick = ($urandom % 2) == 0;
      rx_push = ($urandom % 30) == 0;
      xoff_det = ($urandom % 25) == 0;
      xon_det = ($urandom % 30) == 0;
      sleep_exit = ($urandom % 25) == 0;
      isr_rd = ($urandom % 6) == 0;
      lsr_rd = ($urandom % 12) == 0;
      msr_rd = ($urandom % 12) == 0;
      rhr_rd = ($urandom % 40) == 0;
      thr_wr = ($urandom % 12) == 0;
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule